// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a master for the clause-22 serial management bus used to reach the registers of Ethernet PHYs. Software fills in one user-access word with a PHY address, a register address, a direction and, for a write, sixteen data bits. If the same word also sets the go bit, the block shifts a complete management frame out on MDC and MDIO. The go bit reads back as one for the whole transaction and clears itself when the frame ends.

After a read, the same user-access word holds two results. The acknowledge flag tells whether the PHY pulled the line low during turnaround. The low sixteen bits hold the value shifted in from the PHY. A separate control word enables the interface and sets the divider that gives MDC its rate. Its top bit reports whether the frame engine is idle.

The register port is a single write strobe with a select, plus a combinational read selected by a second select line. The MDIO pin is split into output, output enable and input, so a pad or a bench can resolve it.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0x8000_0000: idle bit 31 is set, enable bit 30 is clear and the divider is zero. The user-access word reads zero. MDC is low and the MDIO output enable is low.
- R2: The user-access word is laid out as follows. Bit 31 is go. Bit 30 selects a write when it is 1 and a read when it is 0. Bit 29 is the acknowledge flag. Bits 25:21 hold the 5-bit register address, bits 20:16 the 5-bit PHY address and bits 15:0 the data. The control word holds enable in bit 30, idle in bit 31 and the divider in its low bits.
- R3: Go reads 1 and idle reads 0 from the moment a transaction is accepted until it completes. Go then clears itself on the same clock edge that drives MDC low for the last time.
- R4: While a transaction runs, MDC has a period of 2*(divider+1) clock cycles. MDC stays low whenever no transaction runs.
- R5: While it is driven, MDIO changes only on clock edges where MDC falls.
- R6: Every frame is sent MSB first in this order: 32 ones, start bits 01, opcode 10 for a read or 01 for a write, the 5-bit PHY address, then the 5-bit register address.
- R7: A write frame drives the turnaround bits as 10 and then the sixteen data bits, keeping the output enable high for all 64 bit times.
- R8: A read frame releases MDIO for the last 18 bit times and samples it on MDC rising edges. The acknowledge flag becomes 1 exactly when the PHY held the second turnaround bit low. The sixteen sampled bits, MSB first, land in data bits 15:0, and the acknowledge flag is 0 after a write.
- R9: A write to the user-access word while go is set has no effect on the running frame or on the stored fields.
- R10: While enable is 0, a write that sets go does not start a frame: go stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 user-access word |
| wr_data | input | 32 | Register write data |
| rd_sel | input | 1 | Read source: 0 control word, 1 user-access word |
| rd_data | output | 32 | Combinational register read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input from the pin |

## Verification
The frame engine is run with both directions, with distinct PHY and register addresses and with data words whose bit patterns are asymmetric. A swapped field, a wrong opcode or a reversed bit order therefore shows up in the captured frame. Reads are tried both with a PHY model that answers and pulls the turnaround low, and with a silent line held high. This separates the acknowledge logic from the data sampling, since a silent PHY must give ACK 0 and all-ones data. One transaction uses a larger divider so that the MDC period scaling can be told apart from a fixed rate. Writes that arrive while the block is busy or disabled are checked through the readback word and through MDC activity.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME_BITS = 64;
  localparam int TA_LAST    = 47;
  localparam int RD_RELEASE = 46;
  localparam int LAST_BIT   = FRAME_BITS - 1;

  logic             en;
  logic [DIV_W-1:0] div;
  logic             go;
  logic             wr_dir;
  logic             ack;
  logic [4:0]       phy_q;
  logic [4:0]       rga_q;
  logic [15:0]      data_q;
  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic [5:0]       bit_idx;
  logic [63:0]      frame;
  logic             tick;

  assign tick  = go && (cnt == div);
  assign frame = {32'hFFFF_FFFF, 2'b01, (wr_dir ? 2'b01 : 2'b10), phy_q, rga_q, 2'b10, data_q};

  assign mdc     = mdc_q;
  assign mdio_o  = frame[6'(LAST_BIT) - bit_idx];
  assign mdio_oe = go && (wr_dir || (bit_idx < 6'(RD_RELEASE)));

  assign rd_data = rd_sel ? {go, wr_dir, ack, 3'b000, rga_q, phy_q, data_q}
                          : {~go, en, {(30-DIV_W){1'b0}}, div};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      div     <= '0;
      go      <= 1'b0;
      wr_dir  <= 1'b0;
      ack     <= 1'b0;
      phy_q   <= '0;
      rga_q   <= '0;
      data_q  <= '0;
      cnt     <= '0;
      mdc_q   <= 1'b0;
      bit_idx <= '0;
    end else begin
      if (wr_en && !wr_sel) begin
        en  <= wr_data[30];
        div <= wr_data[DIV_W-1:0];
      end
      if (wr_en && wr_sel && !go) begin
        go      <= wr_data[31] && en;
        wr_dir  <= wr_data[30];
        ack     <= 1'b0;
        rga_q   <= wr_data[25:21];
        phy_q   <= wr_data[20:16];
        data_q  <= wr_data[15:0];
        cnt     <= '0;
        mdc_q   <= 1'b0;
        bit_idx <= '0;
      end else if (go) begin
        if (tick) begin
          cnt   <= '0;
          mdc_q <= ~mdc_q;
          if (!mdc_q) begin
            if (!wr_dir && bit_idx == 6'(TA_LAST))
              ack <= ~mdio_i;
            if (!wr_dir && bit_idx > 6'(TA_LAST))
              data_q <= {data_q[14:0], mdio_i};
          end else if (bit_idx == 6'(LAST_BIT)) begin
            go      <= 1'b0;
            bit_idx <= '0;
          end else begin
            bit_idx <= bit_idx + 6'd1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       en,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       wr_en,
  input logic       wr_sel,
  input logic       wr_dir,
  input logic [4:0] phy_q,
  input logic [4:0] rga_q,
  input logic [5:0] bit_idx
);
  // R3
  go_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(go) |-> $fell(mdc));

  // R4
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |-> !mdc);

  // R5
  mdio_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_dir && bit_idx >= 6'd46) |-> !mdio_oe);

  // R9
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && wr_en && wr_sel) |=> (go && $stable(phy_q) && $stable(rga_q) && $stable(wr_dir)));

  // R10
  disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !go) |=> !go);
endmodule

bind mdio_master mdio_master_chk u_mdio_master_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .en(en), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .wr_en(wr_en), .wr_sel(wr_sel), .wr_dir(wr_dir),
  .phy_q(phy_q), .rga_q(rga_q), .bit_idx(bit_idx)
);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_sel = 1'b0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  mdio_master i_mdio_master (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int checks = 0;
  int fails  = 0;

  // PHY model
  int          phy_cnt = 0;
  int          ncap = 0;
  logic [63:0] cap = '0;
  logic        phy_ans = 1'b0;
  logic [15:0] phy_resp = '0;
  realtime     t_rise0 = 0, t_rise1 = 0;

  assign mdio_i = (phy_ans && phy_cnt == 47) ? 1'b0 :
                  (phy_ans && phy_cnt >= 48 && phy_cnt <= 63) ? phy_resp[63 - phy_cnt] : 1'b1;

  always @(posedge mdc) begin
    if (phy_cnt == 0) t_rise0 = $realtime;
    if (phy_cnt == 1) t_rise1 = $realtime;
    if (mdio_oe) begin
      cap  = {cap[62:0], mdio_o};
      ncap = ncap + 1;
    end
    phy_cnt = phy_cnt + 1;
  end

  typedef struct {
    logic [63:0] frame;
    int          nbits;
    logic [31:0] word;
    string       req;
  } exp_t;
  exp_t  sb[$];
  logic [31:0] last_word;
  event  xfer_done;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    rd_sel = sel;
    #0.5;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] w;
    do reg_rd(1'b1, w); while (w[31]);
    last_word = w;
  endtask

  // driver: push expected result, start transaction, wait for completion
  task automatic xfer(input logic wr, input logic [4:0] phy, input logic [4:0] rga,
                      input logic [15:0] d, input logic ans, input logic [15:0] resp,
                      input string req);
    exp_t e;
    phy_cnt = 0; ncap = 0; cap = '0;
    phy_ans = ans; phy_resp = resp;
    if (wr) begin
      e.frame = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rga, 2'b10, d};
      e.nbits = 64;
      e.word  = {1'b0, 1'b1, 1'b0, 3'b000, rga, phy, d};
    end else begin
      e.frame = {18'h0, 32'hFFFF_FFFF, 2'b01, 2'b10, phy, rga};
      e.nbits = 46;
      e.word  = {1'b0, 1'b0, ans, 3'b000, rga, phy, (ans ? resp : 16'hFFFF)};
    end
    e.req = req;
    sb.push_back(e);
    reg_wr(1'b1, {1'b1, wr, 4'b0000, rga, phy, d});
    wait_idle();
    -> xfer_done;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      exp_t e;
      @(xfer_done);
      e = sb.pop_front();
      check({e.req, " R6 frame bits"}, cap, e.frame);
      check({e.req, " R7/R8 driven bit count"}, 64'(ncap), 64'(e.nbits));
      check({e.req, " R2/R8 result word"}, {32'h0, last_word}, {32'h0, e.word});
    end
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    reg_rd(1'b0, w); check("R1 control reset", {32'h0, w}, 64'h8000_0000);
    reg_rd(1'b1, w); check("R1 user reset", {32'h0, w}, 64'h0);
    check("R1 mdc/oe reset", {62'h0, mdc, mdio_oe}, 64'h0);

    // R10: go while disabled
    phy_cnt = 0;
    reg_wr(1'b1, 32'hC000_1234);
    repeat (20) @(negedge clk);
    reg_rd(1'b1, w); check("R10 go stays clear", {63'h0, w[31]}, 64'h0);
    check("R10 no mdc activity", 64'(phy_cnt), 64'h0);

    // enable, divider 1
    reg_wr(1'b0, 32'h4000_0001);
    reg_rd(1'b0, w); check("R2 control fields", {32'h0, w}, 64'hC000_0001);

    // write with mid-frame checks (R3, R9)
    fork
      xfer(1'b1, 5'h11, 5'h0A, 16'hA5C3, 1'b0, 16'h0, "write1");
      begin
        repeat (12) @(negedge clk);
        reg_wr(1'b1, 32'h4000_FFFF);
      end
    join
    // R4: divider 1 -> period 4 cycles = 16 ns
    check("R4 mdc period div1", 64'(int'(t_rise1 - t_rise0)), 64'd16);

    // R3 busy observation
    phy_cnt = 0; ncap = 0;
    sb.push_back('{frame: {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h02, 5'h1F, 2'b10, 16'h0F01},
                   nbits: 64, word: {1'b0, 1'b1, 1'b0, 3'b000, 5'h1F, 5'h02, 16'h0F01},
                   req: "write2"});
    cap = '0; phy_ans = 1'b0;
    reg_wr(1'b1, {1'b1, 1'b1, 4'b0000, 5'h1F, 5'h02, 16'h0F01});
    repeat (5) @(negedge clk);
    reg_rd(1'b1, w); check("R3 go set while busy", {63'h0, w[31]}, 64'h1);
    reg_rd(1'b0, w); check("R3 idle clear while busy", {63'h0, w[31]}, 64'h0);
    wait_idle();
    -> xfer_done;
    @(negedge clk);
    reg_rd(1'b0, w); check("R3 idle after completion", {63'h0, w[31]}, 64'h1);
    check("R4 mdc low when idle", {63'h0, mdc}, 64'h0);

    // reads (R8)
    xfer(1'b0, 5'h05, 5'h13, 16'h0000, 1'b1, 16'h3C96, "read ack");
    xfer(1'b0, 5'h1F, 5'h00, 16'h5555, 1'b0, 16'h0000, "read silent");
    xfer(1'b0, 5'h01, 5'h01, 16'h0000, 1'b1, 16'h8001, "read edge bits");

    // divider 3 -> period 8 cycles = 32 ns (R4)
    reg_wr(1'b0, 32'h4000_0003);
    xfer(1'b1, 5'h0C, 5'h15, 16'h1E2D, 1'b0, 16'h0, "write div3");
    check("R4 mdc period div3", 64'(int'(t_rise1 - t_rise0)), 64'd32);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule